// File: doc/BRIEF.md
# Handshaked Processor-Memory Transfer Controller

This block sits between a processor core and a memory whose response time is not fixed. The core hands it a single-word load or store through a request/ready pair. The block latches the target address, the direction and, for a store, the store value into its own registers. It then presents them to the memory with a strobe and holds them there until the memory answers with a completion acknowledge. The number of cycles a transfer takes depends on the memory, not on a fixed count, and can differ from one access to the next.

A load takes its data from the memory's read bus in the cycle the acknowledge is accepted. A store is finished once the acknowledge arrives. Either way, the core then sees a one-cycle done pulse, and for a load that pulse carries the data. Two faults end a transfer early with a flag on the done pulse:
- a byte address that is not word-aligned, which never reaches the memory;
- a memory that stays silent for longer than a parameterised number of wait cycles.

Top module: `mem_xfer_ctrl`

## Requirements
- R1: After reset the block shows `core_ready`=1, `core_done`=0, `mem_valid`=0 and both error flags at 0.
- R2: For an accepted aligned load (`core_we`=0), `mem_valid` rises one cycle after acceptance with `mem_rw`=1 (1 means read) and `mem_addr` equal to the requested address.
- R3: For an accepted aligned store (`core_we`=1), `mem_valid` rises one cycle after acceptance with `mem_rw`=0 (0 means write) and `mem_wdata` equal to the store value.
- R4: `mem_addr`, `mem_rw` and `mem_wdata` do not change while `mem_valid` stays high, which lasts from the first strobe cycle until the acknowledge is accepted.
- R5: For a load, the value on `mem_rdata` in the cycle the acknowledge is accepted appears on `core_rdata` during the done pulse, and this is the word last stored to that address.
- R6: `core_done` is high for exactly one cycle, in the cycle after the acknowledge is accepted, and `mem_valid` is low in that cycle.
- R7: A request is taken only while `core_ready` is high. `core_ready` is low from acceptance through the done cycle, and a request held during that time has no effect on the memory bus.
- R8: If no acknowledge is accepted within TIMEOUT_CYC wait cycles (the strobe cycles after the first), the transfer ends with a done pulse carrying `core_err_timeout`=1. An acknowledge in the last allowed wait cycle still succeeds.
- R9: A request whose address bits [1:0] are not 00 raises `core_done` with `core_err_misalign`=1 in the cycle after acceptance. It never raises `mem_valid` and leaves memory contents unchanged.
- R10: An acknowledge present only in the first strobe cycle is ignored; the transfer keeps waiting and, with no later acknowledge, ends by timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core requests a transfer |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Byte address of the word |
| core_wdata | input | DATA_W | Store value |
| core_ready | output | 1 | Block can accept a request |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load result, valid with done |
| core_err_timeout | output | 1 | Done caused by missing acknowledge |
| core_err_misalign | output | 1 | Done caused by unaligned address |
| mem_valid | output | 1 | Address/direction/data are being presented |
| mem_addr | output | ADDR_W | Address to memory |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_ack | input | 1 | Memory function-complete acknowledge |

## Verification
The bench builds the block with TIMEOUT_CYC=8, ADDR_W=16 and DATA_W=32. The short limit lets responder delays reach both sides of the timeout edge: a delay of exactly eight wait cycles succeeds and nine times out. It also makes the silent-memory and early-pulse cases finish quickly. Delays from zero upward check that an acknowledge held from the first strobe cycle is taken in the first wait cycle, and that read data is captured only in the acknowledge cycle.

// File: rtl/mxc_pkg.sv
package mxc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } mxc_state_e;
endpackage

// File: rtl/mxc_fsm.sv
module mxc_fsm
  import mxc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic       start_bad,
  input  logic       ack,
  input  logic       expired,
  output mxc_state_e state_q
);
  mxc_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_bad)     state_d = ST_DONE;
        else if (start_ok) state_d = ST_DRIVE;
      end
      ST_DRIVE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (ack || expired) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/mxc_timer.sv
module mxc_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LAST);
  assign cnt_en  = clr || (en && !expired);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mxc_regs.sv
module mxc_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              we,
  input  logic              misaligned,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata,
  input  logic              timeout_set,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic              rw_q,
  output logic              to_q,
  output logic              mis_q
);
  logic              mdr_en;
  logic [DATA_W-1:0] mdr_d;
  logic              flag_en;

  assign mdr_en  = (accept && we) || capture;
  assign mdr_d   = capture ? rdata : wdata;
  assign flag_en = accept || timeout_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      rw_q  <= 1'b1;
    end else if (accept) begin
      mar_q <= addr;
      rw_q  <= !we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mdr_q <= '0;
    else if (mdr_en) mdr_q <= mdr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q  <= 1'b0;
      mis_q <= 1'b0;
    end else if (flag_en) begin
      to_q  <= timeout_set;
      mis_q <= accept && misaligned;
    end
  end
endmodule

// File: rtl/mem_xfer_ctrl.sv
module mem_xfer_ctrl
  import mxc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_err_timeout,
  output logic              core_err_misalign,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rw,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  mxc_state_e state_q;
  logic       accept, misaligned, start_ok, start_bad;
  logic       in_drive, in_wait, ack_take, expired, timeout_set, capture;
  logic       rw_q, to_q, mis_q;
  logic [DATA_W-1:0] mdr_q;
  logic [ADDR_W-1:0] mar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign core_ready  = (state_q == ST_IDLE);
  assign misaligned  = (core_addr[1:0] != 2'b00);
  assign accept      = core_ready && core_req;
  assign start_ok    = accept && !misaligned;
  assign start_bad   = accept && misaligned;
  assign in_drive    = (state_q == ST_DRIVE);
  assign in_wait     = (state_q == ST_WAIT);
  assign ack_take    = in_wait && mem_ack;
  assign timeout_set = in_wait && !mem_ack && expired;
  assign capture     = ack_take && rw_q;

  mxc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_ok (start_ok),
    .start_bad(start_bad),
    .ack      (ack_take),
    .expired  (timeout_set),
    .state_q  (state_q)
  );

  mxc_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (in_drive),
    .en     (in_wait),
    .expired(expired)
  );

  mxc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .we         (core_we),
    .misaligned (misaligned),
    .addr       (core_addr),
    .wdata      (core_wdata),
    .capture    (capture),
    .rdata      (mem_rdata),
    .timeout_set(timeout_set),
    .mar_q      (mar_q),
    .mdr_q      (mdr_q),
    .rw_q       (rw_q),
    .to_q       (to_q),
    .mis_q      (mis_q)
  );

  assign core_done         = (state_q == ST_DONE);
  assign core_rdata        = mdr_q;
  assign core_err_timeout  = core_done && to_q;
  assign core_err_misalign = core_done && mis_q;
  assign mem_valid         = in_drive || in_wait;
  assign mem_addr          = mar_q;
  assign mem_rw            = rw_q;
  assign mem_wdata         = mdr_q;
endmodule

// File: rtl/mxc_checker.sv
module mxc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req,
  input logic              core_ready,
  input logic              core_done,
  input logic [ADDR_W-1:0] core_addr,
  input logic [DATA_W-1:0] core_rdata,
  input logic              core_err_timeout,
  input logic              core_err_misalign,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rw,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_ack
);
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid)) |-> ($stable(mem_addr) && $stable(mem_rw) && $stable(mem_wdata))); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done); // R6

  AST_ACK_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid) && mem_ack) |=> (core_done && !core_err_timeout && !mem_valid)); // R6

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid) && mem_ack && mem_rw) |=> (core_rdata == $past(mem_rdata))); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || core_done) |-> !core_ready); // R7

  AST_MISALIGN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_ready && (core_addr[1:0] != 2'b00)) |=> (core_done && core_err_misalign && !mem_valid)); // R9

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_err_timeout && core_err_misalign)); // R8
endmodule

bind mem_xfer_ctrl mxc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .core_req         (core_req),
  .core_ready       (core_ready),
  .core_done        (core_done),
  .core_addr        (core_addr),
  .core_rdata       (core_rdata),
  .core_err_timeout (core_err_timeout),
  .core_err_misalign(core_err_misalign),
  .mem_valid        (mem_valid),
  .mem_addr         (mem_addr),
  .mem_rw           (mem_rw),
  .mem_wdata        (mem_wdata),
  .mem_rdata        (mem_rdata),
  .mem_ack          (mem_ack)
);

// File: tb/mem_xfer_ctrl_bench.sv
module mem_xfer_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req = 1'b0;
  logic          core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic          core_ready, core_done, core_err_timeout, core_err_misalign;
  logic [DW-1:0] core_rdata;
  logic          mem_valid, mem_rw;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  mem_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TO)) u_mem_xfer_ctrl (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ready(core_ready), .core_done(core_done), .core_rdata(core_rdata),
    .core_err_timeout(core_err_timeout), .core_err_misalign(core_err_misalign),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_rw(mem_rw), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // responder memory: 16 words, index = address bits [5:2]
  logic [DW-1:0] mem [16];
  int resp_delay = 1;   // >=0: ack once strobe count reaches it; -1 never; -2 pulse in first strobe cycle only
  int vcnt = 0;

  // behavioural reference: 0 idle, 1 first strobe cycle, 2 waiting, 3 done
  int            m_ph = 0;
  int            m_wait = 0;
  logic [AW-1:0] m_addr = '0;
  logic          m_rd = 1'b1;
  logic [DW-1:0] m_wd = '0;
  logic [DW-1:0] m_rdv = '0;
  logic          m_to = 1'b0;
  logic          m_mis = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0;
    end else begin
      case (m_ph)
        0: if (core_req) begin
             if (core_addr[1:0] != 2'b00) begin m_ph = 3; m_mis = 1; m_to = 0; end
             else begin
               m_ph = 1; m_mis = 0; m_to = 0;
               m_addr = core_addr; m_rd = !core_we; m_wd = core_wdata;
             end
           end
        1: begin m_ph = 2; m_wait = 0; end
        2: begin
             if (mem_ack) begin m_ph = 3; if (m_rd) m_rdv = mem_rdata; end
             else if (m_wait == TO - 1) begin m_ph = 3; m_to = 1; end
             else m_wait++;
           end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && cyc > 1) begin
      chk("R7 ready", core_ready, m_ph == 0);
      chk("R6 done", core_done, m_ph == 3);
      chk("R6 strobe", mem_valid, (m_ph == 1) || (m_ph == 2));
      if (m_ph == 1 || m_ph == 2) begin
        chk("R2 addr", mem_addr, m_addr);
        chk("R2 rw", mem_rw, m_rd);
        if (!m_rd) chk("R3 wdata", mem_wdata, m_wd);
      end
      if (m_ph == 3) begin
        chk("R8 timeout flag", core_err_timeout, m_to);
        chk("R9 misalign flag", core_err_misalign, m_mis);
        if (m_rd && !m_to && !m_mis) chk("R5 rdata", core_rdata, m_rdv);
      end
    end
    // responder
    if (!mem_valid) begin
      vcnt = 0; mem_ack = 1'b0; mem_rdata = 32'hBAD0_0000;
    end else begin
      mem_ack = (resp_delay >= 0 && vcnt >= resp_delay) || (resp_delay == -2 && vcnt == 0);
      mem_rdata = mem_ack ? mem[mem_addr[5:2]] : (32'hBAD0_0000 | DW'(vcnt));
      if (mem_ack && !mem_rw) mem[mem_addr[5:2]] = mem_wdata;
      vcnt++;
    end
  end

  logic [DW-1:0] got_rdata;
  logic          got_to, got_mis;

  task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int dly, input bit hold_req);
    int n;
    resp_delay = dly;
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    @(negedge clk);
    if (!hold_req) core_req = 1'b0;
    else begin core_addr = a ^ 16'h0040; core_we = !we; end
    n = 0;
    while (!core_done && n < 100) begin @(negedge clk); n++; end
    core_req = 1'b0;
    got_rdata = core_rdata; got_to = core_err_timeout; got_mis = core_err_misalign;
    if (n >= 100) chk("R6 done seen", 1'b0, 1'b1);
  endtask

  logic [DW-1:0] ref_mem [16];

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input int dly);
    xfer(1'b1, a, d, dly, 1'b0);
    chk("R3 store ok", {got_to, got_mis}, 2'b00);
    ref_mem[a[5:2]] = d;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input int dly);
    xfer(1'b0, a, '0, dly, 1'b0);
    chk("R5 load ok", {got_to, got_mis}, 2'b00);
    chk("R5 load value", got_rdata, ref_mem[a[5:2]]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h1000_0000 + i; ref_mem[i] = 32'h1000_0000 + i; end
    repeat (3) @(negedge clk);
    chk("R1 ready", core_ready, 1'b1);
    chk("R1 done", core_done, 1'b0);
    chk("R1 strobe", mem_valid, 1'b0);
    chk("R1 flags", {core_err_timeout, core_err_misalign}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {core_ready, mem_valid, core_done}, 3'b100);

    do_store(16'h0010, 32'hA5A5_0001, 3);
    do_load (16'h0010, 1);
    do_store(16'h0024, 32'h5A5A_0002, TO);          // R8 last allowed wait cycle
    do_load (16'h0024, 0);                          // ack held from first strobe cycle
    do_load (16'h0008, 2);

    xfer(1'b0, 16'h0010, '0, TO + 1, 1'b0);
    chk("R8 one cycle late times out", got_to, 1'b1);
    xfer(1'b0, 16'h0010, '0, -1, 1'b0);
    chk("R8 silent memory times out", got_to, 1'b1);
    xfer(1'b0, 16'h0010, '0, -2, 1'b0);
    chk("R10 early ack ignored", {got_to, got_mis}, 2'b10);

    xfer(1'b1, 16'h0012, 32'hDEAD_BEEF, 1, 1'b0);
    chk("R9 misaligned store flagged", {got_to, got_mis}, 2'b01);
    do_load(16'h0010, 1);                           // R9 memory untouched
    xfer(1'b0, 16'h0003, '0, 1, 1'b0);
    chk("R9 misaligned load flagged", got_mis, 1'b1);

    xfer(1'b1, 16'h0030, 32'hC0DE_0003, 5, 1'b1);  // R7 request held while busy
    chk("R7 held store ok", {got_to, got_mis}, 2'b00);
    ref_mem[12] = 32'hC0DE_0003;
    do_load(16'h0030, 4);
    do_load(16'h0070, 1);                           // R7 aliased word not written by held request

    for (int k = 0; k < 6; k++) do_store(AW'(k * 4), 32'h7700_0000 + k * 3, k);
    for (int k = 0; k < 6; k++) do_load(AW'(k * 4), 5 - k);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule